// File: doc/BRIEF.md
# Dual-Bank Maskable Interrupt Controller

This block collects single-cycle event pulses from surrounding logic into two 32-bit flag banks. Each bank pairs its flags with a 32-bit enable mask and drives its own active-low request line toward a host processor. The host reaches flags, masks, a command register and a set of per-phase detail latches through a synchronous register port. It clears flags by writing ones, so writing back a value it has just read clears exactly the events it has seen. Events that arrive during service are never lost.

Bank 1 bit 15 is a completion flag for the reset sequence. It is raised at the end of every hardware or software reset, and it pulls request line 1 low whatever the mask says. Eight summary flags each have a three-bit phase latch that records which phases reported activity while that summary flag was up. The host reads the latch before it clears the summary flag. Clearing the summary flag also empties the latch.

Top module: `irqc_top`

## Requirements
- R1: A pulse on event bit i sets flag i of its bank in the next clock, whether or not mask bit i is set.
- R2: Writing the status address of a bank clears each flag whose written data bit is 1. Flags whose written bit is 0 keep their value.
- R3: A request line is low exactly when its bank had an enabled flag set in the previous cycle, so the line moves one clock after the flag or mask change that causes it.
- R4: After any reset sequence both mask registers read 0 and both request lines are high, apart from the effect of R5.
- R5: Bank 1 flag bit 15 is set PRE_CYC clocks after reset is released, and it drives request line 1 low whatever is in mask 1. Mask 1 bit 15 always reads 0, and event input bit 15 of bank 1 has no effect.
- R6: Writing address 4 with data bit 0 set starts a software reset. During the sequence, address 4 reads 1. At the end of the sequence all flags and masks are 0, except that bank 1 bit 15 is set.
- R7: When an event pulse and a clear-write of the same flag occur in the same cycle, the flag stays 1.
- R8: Detail latch k holds phase inputs ph_evt_i[3k+2:3k]. It ORs in those inputs in every cycle in which its summary flag is set after that cycle's update. This includes the cycle in which the summary flag gets set. In all other cycles the phase inputs are ignored. Latches 0 to 7 belong to bank 0 bits 6, 7, 8 and bank 1 bits 16, 17, 18, 23, 24, and they are read at addresses 5 to 12.
- R9: A detail latch reads 0 from the same clock in which its summary flag is cleared.
- R10: Read data appears one clock after read enable. The address map is: 0 is status 0, 1 is mask 0, 2 is status 1, 3 is mask 1, 4 is the command register, 5 to 12 are the detail latches, and all other addresses read 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | clock |
| rst | input | 1 | synchronous active-high reset; starts the reset sequence |
| evt0_i | input | 32 | event pulses for bank 0 |
| evt1_i | input | 32 | event pulses for bank 1 (bit 15 ignored) |
| ph_evt_i | input | 24 | per-phase pulses, three per detail latch |
| addr_i | input | 4 | register address |
| wr_en_i | input | 1 | write strobe |
| wr_data_i | input | 32 | write data |
| rd_en_i | input | 1 | read strobe |
| rd_data_o | output | 32 | registered read data |
| irq0_n_o | output | 1 | active-low request line of bank 0 |
| irq1_n_o | output | 1 | active-low request line of bank 1 |

## Verification
The bench sweeps every bit of both banks through set, enable, and clear, and samples the request line in both the cycle before and the cycle after each change. A design with a combinational line, or with a line that lags by two cycles, fails these checks. Collisions between an event and a clear of the same bit are driven on purpose, and a design that lets the clear win drops the flag. The bench attempts to mask the completion flag, feeds its event bit, and issues a soft reset over live masks and flags. This catches a maskable completion bit, masks that survive the reset, or a missing completion flag. The detail latches receive phase pulses before, during, and at the clearing of their summary flag, which exposes latches that capture while idle or that are not emptied on clear.

// File: rtl/irqc_pkg.sv
package irqc_pkg;
  localparam int unsigned DATA_W  = 32;
  localparam int unsigned ADDR_W  = 4;
  localparam int unsigned NPH     = 3;
  localparam int unsigned NDET    = 8;
  localparam int unsigned DONE_BIT = 15;

  typedef enum logic [ADDR_W-1:0] {
    A_STAT0 = 4'd0,
    A_MASK0 = 4'd1,
    A_STAT1 = 4'd2,
    A_MASK1 = 4'd3,
    A_CMD   = 4'd4,
    A_DET   = 4'd5
  } reg_addr_e;

  // flag position that owns detail latch k
  function automatic int unsigned det_pos(input int unsigned k);
    case (k)
      0: det_pos = 6;
      1: det_pos = 7;
      2: det_pos = 8;
      3: det_pos = 16;
      4: det_pos = 17;
      5: det_pos = 18;
      6: det_pos = 23;
      default: det_pos = 24;
    endcase
  endfunction

  // 1 when detail latch k belongs to bank 1
  function automatic bit det_in_b1(input int unsigned k);
    det_in_b1 = (k >= 3);
  endfunction
endpackage

// File: rtl/irqc_rst_seq.sv
module irqc_rst_seq #(
  parameter int unsigned CYC = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic busy_o,
  output logic done_o
);
  localparam int unsigned CW   = $clog2(CYC + 1);
  localparam logic [CW-1:0] LAST = CW'(CYC - 1);

  logic [CW-1:0] cnt_q;
  logic          busy_q;

  always_ff @(posedge clk) begin
    if (rst || start_i) begin
      busy_q <= 1'b1;
      cnt_q  <= '0;
    end else if (busy_q) begin
      if (cnt_q == LAST) busy_q <= 1'b0;
      else               cnt_q  <= cnt_q + 1'b1;
    end
  end

  assign busy_o = busy_q;
  assign done_o = busy_q && (cnt_q == LAST) && !start_i;

  AST_SEQ_ENDS_ON_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy_q) |-> $past(done_o)); // R5
endmodule

// File: rtl/irqc_bank.sv
module irqc_bank #(
  parameter int unsigned W = 32,
  parameter logic [W-1:0] NM = '0
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         init_i,
  input  logic [W-1:0] evt_i,
  input  logic [W-1:0] force_i,
  input  logic         clr_we_i,
  input  logic         mask_we_i,
  input  logic [W-1:0] wdata_i,
  output logic [W-1:0] status_q_o,
  output logic [W-1:0] status_d_o,
  output logic [W-1:0] mask_q_o,
  output logic         irq_n_o
);
  logic [W-1:0] status_q, status_d, mask_q, clr_vec;
  logic         irq_n_q;

  assign clr_vec  = clr_we_i ? wdata_i : '0;
  // the set path is ORed in last, so it wins over a clear in the same cycle
  assign status_d = init_i ? force_i
                           : ((status_q & ~clr_vec) | evt_i | force_i);

  always_ff @(posedge clk) begin
    if (rst) status_q <= '0;
    else     status_q <= status_d;
  end

  always_ff @(posedge clk) begin
    if (rst || init_i) mask_q <= '0;
    else if (mask_we_i) mask_q <= wdata_i & ~NM;
  end

  always_ff @(posedge clk) begin
    if (rst) irq_n_q <= 1'b1;
    else     irq_n_q <= ~|(status_q & (mask_q | NM));
  end

  assign status_q_o = status_q;
  assign status_d_o = status_d;
  assign mask_q_o   = mask_q;
  assign irq_n_o    = irq_n_q;

  AST_EVT_SETS_FLAG: assert property (@(posedge clk) disable iff (rst)
    (!init_i && |evt_i) |=> ((status_q & $past(evt_i)) == $past(evt_i))); // R1
  AST_ONLY_W1C_CLEARS: assert property (@(posedge clk) disable iff (rst)
    (!init_i && !clr_we_i) |=> ((status_q & $past(status_q)) == $past(status_q))); // R2
  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (rst)
    $fell(irq_n_q) |-> ($past(status_q) != '0)); // R3
endmodule

// File: rtl/irqc_detail.sv
module irqc_detail #(
  parameter int unsigned NPH = 3
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           flag_d_i,
  input  logic           flag_q_i,
  input  logic [NPH-1:0] ph_i,
  output logic [NPH-1:0] det_o
);
  logic [NPH-1:0] det_q;

  always_ff @(posedge clk) begin
    if (rst)           det_q <= '0;
    else if (flag_d_i) det_q <= det_q | ph_i;
    else               det_q <= '0;
  end

  assign det_o = det_q;

  AST_DET_EMPTY_WHEN_IDLE: assert property (@(posedge clk) disable iff (rst)
    !flag_q_i |-> (det_q == '0)); // R9
endmodule

// File: rtl/irqc_top.sv
module irqc_top
  import irqc_pkg::*;
#(
  parameter int unsigned PRE_CYC = 8
) (
  input  logic                  clk,
  input  logic                  rst,
  input  logic [DATA_W-1:0]     evt0_i,
  input  logic [DATA_W-1:0]     evt1_i,
  input  logic [NDET*NPH-1:0]   ph_evt_i,
  input  logic [ADDR_W-1:0]     addr_i,
  input  logic                  wr_en_i,
  input  logic [DATA_W-1:0]     wr_data_i,
  input  logic                  rd_en_i,
  output logic [DATA_W-1:0]     rd_data_o,
  output logic                  irq0_n_o,
  output logic                  irq1_n_o
);
  localparam logic [DATA_W-1:0] NM1 = DATA_W'(1) << DONE_BIT;

  logic busy, done, sw_start;
  logic [DATA_W-1:0] st0_q, st0_d, mk0_q, st1_q, st1_d, mk1_q, force1;
  logic [NPH-1:0]    det_q [NDET];
  logic [DATA_W-1:0] rd_mux, rd_q;

  assign sw_start = wr_en_i && (addr_i == A_CMD) && wr_data_i[0];
  assign force1   = done ? NM1 : '0;

  irqc_rst_seq #(.CYC(PRE_CYC)) u_seq (
    .clk(clk), .rst(rst), .start_i(sw_start), .busy_o(busy), .done_o(done)
  );

  irqc_bank #(.W(DATA_W), .NM('0)) u_bank0 (
    .clk(clk), .rst(rst), .init_i(busy), .evt_i(evt0_i), .force_i('0),
    .clr_we_i(wr_en_i && !busy && (addr_i == A_STAT0)),
    .mask_we_i(wr_en_i && !busy && (addr_i == A_MASK0)),
    .wdata_i(wr_data_i), .status_q_o(st0_q), .status_d_o(st0_d),
    .mask_q_o(mk0_q), .irq_n_o(irq0_n_o)
  );

  irqc_bank #(.W(DATA_W), .NM(NM1)) u_bank1 (
    .clk(clk), .rst(rst), .init_i(busy), .evt_i(evt1_i & ~NM1), .force_i(force1),
    .clr_we_i(wr_en_i && !busy && (addr_i == A_STAT1)),
    .mask_we_i(wr_en_i && !busy && (addr_i == A_MASK1)),
    .wdata_i(wr_data_i), .status_q_o(st1_q), .status_d_o(st1_d),
    .mask_q_o(mk1_q), .irq_n_o(irq1_n_o)
  );

  for (genvar k = 0; k < NDET; k++) begin : g_det
    localparam int unsigned POS = det_pos(k);
    logic fd, fq;
    if (det_in_b1(k)) begin : g_b1
      assign fd = st1_d[POS];
      assign fq = st1_q[POS];
    end else begin : g_b0
      assign fd = st0_d[POS];
      assign fq = st0_q[POS];
    end
    irqc_detail #(.NPH(NPH)) u_det (
      .clk(clk), .rst(rst), .flag_d_i(fd), .flag_q_i(fq),
      .ph_i(ph_evt_i[k*NPH +: NPH]), .det_o(det_q[k])
    );
  end

  always_comb begin
    rd_mux = '0;
    case (addr_i)
      A_STAT0: rd_mux = st0_q;
      A_MASK0: rd_mux = mk0_q;
      A_STAT1: rd_mux = st1_q;
      A_MASK1: rd_mux = mk1_q;
      A_CMD:   rd_mux = {{(DATA_W-1){1'b0}}, busy};
      default: begin
        for (int k = 0; k < NDET; k++)
          if (addr_i == ADDR_W'(int'(A_DET) + k)) rd_mux = {{(DATA_W-NPH){1'b0}}, det_q[k]};
      end
    endcase
  end

  always_ff @(posedge clk) begin
    if (rst)          rd_q <= '0;
    else if (rd_en_i) rd_q <= rd_mux;
  end
  assign rd_data_o = rd_q;

  AST_DONE_FLAG_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> st1_q[DONE_BIT]); // R5
  AST_MASKS_CLEAR_ON_EXIT: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (mk0_q == '0 && mk1_q == '0)); // R4
  AST_SEQ_LEAVES_ONLY_DONE: assert property (@(posedge clk) disable iff (rst)
    $fell(busy) |-> (st0_q == '0 && st1_q == NM1)); // R6
endmodule

// File: tb/sim_irqc_top.sv
module sim_irqc_top;
  localparam int PRE = 8;
  logic clk = 0, rst = 1;
  logic [31:0] evt0 = 0, evt1 = 0, wdata = 0;
  logic [23:0] ph = 0;
  logic [3:0]  addr = 0;
  logic wr_en = 0, rd_en = 0;
  logic [31:0] rdata;
  logic irq0_n, irq1_n;
  int vec = 0, bad = 0;
  bit finished = 0;

  always #10 clk = ~clk;

  irqc_top #(.PRE_CYC(PRE)) u0 (
    .clk(clk), .rst(rst), .evt0_i(evt0), .evt1_i(evt1), .ph_evt_i(ph),
    .addr_i(addr), .wr_en_i(wr_en), .wr_data_i(wdata), .rd_en_i(rd_en),
    .rd_data_o(rdata), .irq0_n_o(irq0_n), .irq1_n_o(irq1_n)
  );

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    vec++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic tick(); @(posedge clk); @(negedge clk); endtask

  task automatic wr(input logic [3:0] a, input logic [31:0] d);
    addr = a; wdata = d; wr_en = 1; tick(); wr_en = 0;
  endtask

  task automatic rd(input logic [3:0] a, output logic [31:0] d);
    addr = a; rd_en = 1; tick(); rd_en = 0; d = rdata;
  endtask

  task automatic pulse(input int bank, input logic [31:0] v, input logic [23:0] p);
    if (bank == 0) evt0 = v; else evt1 = v;
    ph = p; tick(); evt0 = 0; evt1 = 0; ph = 0;
  endtask

  task automatic sweep(input int bank);
    logic [31:0] d, b;
    logic [3:0] sa, ma;
    sa = (bank == 0) ? 4'd0 : 4'd2;
    ma = (bank == 0) ? 4'd1 : 4'd3;
    for (int i = 0; i < 32; i++) begin
      if (bank == 1 && i == 15) continue;
      b = 32'd1 << i;
      pulse(bank, b, 0);
      rd(sa, d); chk("R1 flag set with mask clear", d, b);
      chk("R1 line idle while masked", (bank == 0) ? irq0_n : irq1_n, 1);
      wr(ma, b);
      chk("R3 line waits one clock after mask", (bank == 0) ? irq0_n : irq1_n, 1);
      tick();
      chk("R3 line low on enabled flag", (bank == 0) ? irq0_n : irq1_n, 0);
      wr(sa, ~b); rd(sa, d); chk("R2 write of zero keeps flag", d, b);
      wr(sa, b);
      chk("R3 line still low one clock after clear", (bank == 0) ? irq0_n : irq1_n, 0);
      tick();
      chk("R3 line high after clear", (bank == 0) ? irq0_n : irq1_n, 1);
      rd(sa, d); chk("R2 write one clears flag", d, 0);
      wr(ma, 0);
    end
  endtask

  initial begin
    logic [31:0] d;
    @(negedge clk); @(negedge clk); rst = 0;
    chk("R4 irq0 high after reset", irq0_n, 1);
    chk("R4 irq1 high before done", irq1_n, 1);
    rd(4'd4, d); chk("R6 busy during sequence", d, 1);
    repeat (PRE + 2) tick();
    rd(4'd2, d); chk("R5 done flag set", d, 32'h0000_8000);
    chk("R5 done drives line 1 with mask clear", irq1_n, 0);
    rd(4'd1, d); chk("R4 mask0 zero", d, 0);
    rd(4'd3, d); chk("R4 mask1 zero", d, 0);
    rd(4'd4, d); chk("R6 idle command", d, 0);
    rd(4'd15, d); chk("R10 unmapped reads zero", d, 0);
    wr(4'd3, 32'hFFFF_FFFF); rd(4'd3, d); chk("R5 mask1 bit 15 reads zero", d, 32'hFFFF_7FFF);
    wr(4'd3, 0); tick(); chk("R5 line stays low with mask off", irq1_n, 0);
    wr(4'd2, 32'h0000_8000); tick(); tick();
    chk("R5 line released after done cleared", irq1_n, 1);
    pulse(1, 32'h0000_8000, 0); rd(4'd2, d); chk("R5 event bit 15 ignored", d, 0);

    sweep(0);
    sweep(1);

    // R7 set and clear colliding
    pulse(0, 32'h0000_0010, 0);
    addr = 0; wdata = 32'h0000_0010; wr_en = 1; evt0 = 32'h0000_0010;
    tick(); wr_en = 0; evt0 = 0;
    rd(4'd0, d); chk("R7 set wins over clear", d, 32'h0000_0010);
    wr(4'd0, 32'h0000_0010); rd(4'd0, d); chk("R7 later clear works", d, 0);

    // R8 / R9 detail latches
    pulse(0, 0, 24'b001); rd(4'd5, d); chk("R8 phase ignored while summary idle", d, 0);
    pulse(1, 32'h0001_0000, 24'b001 << 9); rd(4'd8, d); chk("R8 capture on set cycle", d, 3'b001);
    pulse(1, 0, 24'b100 << 9); rd(4'd8, d); chk("R8 OR accumulate", d, 3'b101);
    rd(4'd9, d); chk("R8 neighbour latch untouched", d, 0);
    addr = 2; wdata = 32'h0001_0000; wr_en = 1; ph = 24'b010 << 9;
    tick(); wr_en = 0; ph = 0;
    rd(4'd8, d); chk("R9 latch emptied with summary", d, 0);
    pulse(1, 32'h0100_0000, 24'b110 << 21); rd(4'd12, d); chk("R8 voltage peak latch", d, 3'b110);
    addr = 2; wdata = 32'h0100_0000; wr_en = 1; evt1 = 32'h0100_0000; ph = 24'b001 << 21;
    tick(); wr_en = 0; evt1 = 0; ph = 0;
    rd(4'd12, d); chk("R7 latch kept when set beats clear", d, 3'b111);
    wr(4'd2, 32'h0100_0000); rd(4'd12, d); chk("R9 latch cleared", d, 0);

    // R6 soft reset over live state
    wr(4'd1, 32'hA5A5_A5A5); wr(4'd3, 32'h0F0F_0F0F);
    pulse(0, 32'h1234_5678, 0); pulse(1, 32'h0000_0040, 0);
    wr(4'd4, 32'h1); rd(4'd4, d); chk("R6 busy after command", d, 1);
    repeat (PRE + 2) tick();
    rd(4'd0, d); chk("R6 flags0 cleared", d, 0);
    rd(4'd2, d); chk("R6 only done flag in bank1", d, 32'h0000_8000);
    rd(4'd1, d); chk("R6 mask0 cleared", d, 0);
    rd(4'd3, d); chk("R6 mask1 cleared", d, 0);
    tick(); chk("R4 irq0 high after soft reset", irq0_n, 1);
    chk("R5 irq1 low after soft reset", irq1_n, 0);

    finished = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
    $finish;
  end

  initial begin
    repeat (150000) @(posedge clk);
    if (!finished) begin
      vec++; bad++;
      $display("FAIL watchdog actual=running expected=done");
      $display("== %0d vectors applied, %0d miscompares ==", vec, bad);
      $finish;
    end
  end
endmodule